// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes a stream of received bytes, each of which may carry an end-of-message marker, and places them into memory buffers. The buffers are described by a ring of 8-byte descriptors held in a descriptor memory. The engine reads the current descriptor through a 16-bit synchronous port. It writes payload bytes one at a time through a byte write port. When a buffer is finished, the engine writes back the length and then the status. It then moves to the next descriptor, or back to the ring base when the descriptor is marked as the last one in the ring.

Software prepares the descriptors and marks each one free by setting its Empty flag. It supplies the ring base address and the maximum number of bytes per buffer, then raises the enable input. A buffer is closed in one of two ways. Either a down-counter, loaded from the maximum length when the buffer opens, runs out, or the incoming byte carries the end-of-message marker. A one-cycle interrupt pulse follows the close of any descriptor that asks for one.

The receive side cannot be stalled. A byte that arrives while the engine is between buffers is lost. If the engine is fetching or writing back, the loss is reported in the next buffer's status as an overrun. If the engine is waiting for software to release a descriptor, the loss raises a sticky busy output.

Top module: `rx_bd_ring`

## Requirements
- R1: Descriptor layout, as byte offsets within an 8-byte descriptor. The status halfword is at +0 and the length at +2. The buffer address is split into a high half at +4 and a low half at +6. Reads return data one cycle after the address. Bits [2:0] of the ring base are treated as zero. While enable is low the engine stays idle, holds its pointer at the ring base and ignores received bytes. The first status read after enable rises addresses the ring base.
- R2: Accepted bytes are written to consecutive byte addresses, starting at the descriptor's buffer address, in arrival order, with one write per accepted byte.
- R3: The byte down-counter is loaded from the maximum length when a buffer opens. A buffer that reaches the maximum is closed with length equal to that maximum and the Last flag (bit 11) clear. A change to the maximum length during a buffer takes effect only at the next descriptor.
- R4: A byte carrying the end-of-message marker closes the buffer early. The written length is the number of bytes held, and the Last flag (bit 11) is set.
- R5: Closing writes the length halfword (+2) first and the status halfword (+0) in the following cycle. In the written status, Empty (bit 15) is cleared. Wrap (bit 13), Interrupt (bit 12) and continuous mode (bit 9) keep their fetched values.
- R6: When continuous mode (bit 9) is set in the descriptor, Empty (bit 15) stays set in the written status.
- R7: After a close the pointer advances by 8 bytes. If Wrap (bit 13) was set, the pointer returns to the ring base instead.
- R8: The interrupt output is a one-cycle pulse in the cycle after the status write. It is issued only when Interrupt (bit 12) of the closed descriptor is set.
- R9: A byte arriving while the engine fetches a descriptor or writes one back is dropped. Overrun (bit 1) is then set in the status of the next buffer closed. Such a drop does not raise the busy output.
- R10: A fetched descriptor with Empty (bit 15) clear is polled by re-reading its status until Empty is set. Bytes arriving meanwhile are dropped, and the busy output is raised and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Engine enable |
| ringBase | input | ADDR_W | Byte address of the first descriptor (low 3 bits ignored) |
| maxLen | input | 16 | Maximum bytes per buffer, nonzero |
| rxValid | input | 1 | Received byte present this cycle |
| rxByte | input | 8 | Received byte |
| rxEnd | input | 1 | This byte ends the message |
| dAddr | output | ADDR_W | Descriptor memory byte address (halfword aligned) |
| dWe | output | 1 | Descriptor memory write strobe |
| dWdata | output | 16 | Descriptor memory write data |
| dRdata | input | 16 | Descriptor memory read data, one cycle after dAddr |
| bWe | output | 1 | Buffer byte write strobe |
| bAddr | output | 32 | Buffer byte address |
| bData | output | 8 | Buffer byte data |
| irq | output | 1 | One-cycle interrupt pulse |
| busyFlag | output | 1 | Sticky: bytes lost while no free descriptor |

## Verification
The hardest state to reach is a buffer that carries the overrun flag while the engine is also waiting for a free descriptor. Both kinds of loss must be told apart, because only one of them may set the sticky busy output. The stimulus sends one byte more than the maximum back to back, so the extra byte lands in the write-back cycle. The ring then wraps onto a descriptor already consumed, and a further byte arrives while that descriptor is being polled. The bench then releases the descriptor with continuous mode set and checks that the buffer closes with Overrun set and Empty kept. During that same buffer the maximum length is lowered, which shows that the change only takes effect at the following descriptor.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int HW = 16;
  localparam int BIT_E  = 15;
  localparam int BIT_W  = 13;
  localparam int BIT_I  = 12;
  localparam int BIT_L  = 11;
  localparam int BIT_CM = 9;
  localparam int BIT_OV = 1;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ST, S_RD_HI, S_RD_LO, S_LOAD, S_OPEN, S_WB_LEN, S_WB_ST
  } rxrState_t;

  typedef struct packed {
    logic       loadBase;
    logic       capStat;
    logic       capHi;
    logic       capLo;
    logic       accept;
    logic       wrLen;
    logic       wrStat;
    logic       advance;
    logic       dropOv;
    logic       dropBusy;
    logic [2:0] addrOff;
  } rxrStrobe_t;
endpackage

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       rxValid,
  input  logic       rxEnd,
  input  logic       rdEmpty,
  input  logic       cntLast,
  output rxrStrobe_t stb
);
  rxrState_t state, nxt;
  logic      notReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      notReady <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_RD_HI)     notReady <= !rdEmpty;
      else if (state == S_IDLE) notReady <= 1'b0;
    end
  end

  always_comb begin
    stb = '0;
    nxt = state;
    unique case (state)
      S_IDLE: begin
        stb.loadBase = 1'b1;
        if (enable) nxt = S_RD_ST;
      end
      S_RD_ST: begin
        stb.addrOff = 3'd0;
        nxt = S_RD_HI;
      end
      S_RD_HI: begin
        stb.addrOff = 3'd4;
        stb.capStat = 1'b1;
        nxt = rdEmpty ? S_RD_LO : S_RD_ST;
      end
      S_RD_LO: begin
        stb.addrOff = 3'd6;
        stb.capHi = 1'b1;
        nxt = S_LOAD;
      end
      S_LOAD: begin
        stb.capLo = 1'b1;
        nxt = S_OPEN;
      end
      S_OPEN: begin
        if (rxValid) begin
          stb.accept = 1'b1;
          if (rxEnd || cntLast) nxt = S_WB_LEN;
        end
      end
      S_WB_LEN: begin
        stb.addrOff = 3'd2;
        stb.wrLen = 1'b1;
        nxt = S_WB_ST;
      end
      S_WB_ST: begin
        stb.addrOff = 3'd0;
        stb.wrStat = 1'b1;
        stb.advance = 1'b1;
        nxt = enable ? S_RD_ST : S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
    if (rxValid && state != S_OPEN && state != S_IDLE) begin
      if (notReady) stb.dropBusy = 1'b1;
      else          stb.dropOv   = 1'b1;
    end
  end
endmodule

// File: rtl/rxr_datapath.sv
module rxr_datapath
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxrStrobe_t        stb,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [HW-1:0]     maxLen,
  input  logic [7:0]        rxByte,
  input  logic              rxEnd,
  input  logic [HW-1:0]     dRdata,
  output logic [ADDR_W-1:0] dAddr,
  output logic              dWe,
  output logic [HW-1:0]     dWdata,
  output logic              bWe,
  output logic [2*HW-1:0]   bAddr,
  output logic [7:0]        bData,
  output logic              irq,
  output logic              busyFlag,
  output logic              rdEmpty,
  output logic              cntLast
);
  localparam int BUF_AW = 2 * HW;
  localparam logic [ADDR_W-1:0] DESC_BYTES = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(7);

  logic [ADDR_W-1:0] ptr, baseAligned;
  logic [HW-1:0]     stat, bufHi, cnt, lenCnt, closeStat;
  logic [BUF_AW-1:0] bufPtr;
  logic              endSeen, ovPending, ovBuf;

  assign baseAligned = ringBase & ALIGN_MASK;
  assign rdEmpty     = dRdata[BIT_E];
  assign cntLast     = (cnt == HW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else if (stb.loadBase) ptr <= baseAligned;
    else if (stb.advance) ptr <= stat[BIT_W] ? baseAligned : ptr + DESC_BYTES;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stat <= '0;
      bufHi <= '0;
    end else begin
      if (stb.capStat) stat <= dRdata;
      if (stb.capHi) bufHi <= dRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufPtr <= '0; cnt <= '0; lenCnt <= '0; endSeen <= 1'b0;
      bWe <= 1'b0; bAddr <= '0; bData <= '0;
    end else begin
      bWe <= 1'b0;
      if (stb.capLo) begin
        bufPtr  <= {bufHi, dRdata};
        cnt     <= maxLen;
        lenCnt  <= '0;
        endSeen <= 1'b0;
      end else if (stb.accept) begin
        bWe     <= 1'b1;
        bAddr   <= bufPtr;
        bData   <= rxByte;
        bufPtr  <= bufPtr + BUF_AW'(1);
        cnt     <= cnt - HW'(1);
        lenCnt  <= lenCnt + HW'(1);
        endSeen <= rxEnd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovPending <= 1'b0; ovBuf <= 1'b0; busyFlag <= 1'b0; irq <= 1'b0;
    end else begin
      if (stb.capLo) begin
        ovBuf     <= ovPending | stb.dropOv;
        ovPending <= 1'b0;
      end else begin
        ovPending <= ovPending | stb.dropOv;
      end
      busyFlag <= busyFlag | stb.dropBusy;
      irq      <= stb.wrStat & stat[BIT_I];
    end
  end

  always_comb begin
    closeStat         = stat;
    closeStat[BIT_E]  = stat[BIT_CM];
    closeStat[BIT_L]  = endSeen;
    closeStat[BIT_OV] = ovBuf;
  end

  assign dAddr  = ptr | ADDR_W'(stb.addrOff);
  assign dWe    = stb.wrLen | stb.wrStat;
  assign dWdata = stb.wrLen ? lenCnt : closeStat;
endmodule

// File: rtl/rx_bd_ring.sv
module rx_bd_ring
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [15:0]       maxLen,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              rxEnd,
  output logic [ADDR_W-1:0] dAddr,
  output logic              dWe,
  output logic [15:0]       dWdata,
  input  logic [15:0]       dRdata,
  output logic              bWe,
  output logic [31:0]       bAddr,
  output logic [7:0]        bData,
  output logic              irq,
  output logic              busyFlag
);
  rxrStrobe_t stb;
  logic       rdEmpty, cntLast;

  rxr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .rxValid(rxValid), .rxEnd(rxEnd),
    .rdEmpty(rdEmpty), .cntLast(cntLast), .stb(stb)
  );

  rxr_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ringBase(ringBase), .maxLen(maxLen),
    .rxByte(rxByte), .rxEnd(rxEnd), .dRdata(dRdata), .dAddr(dAddr), .dWe(dWe),
    .dWdata(dWdata), .bWe(bWe), .bAddr(bAddr), .bData(bData), .irq(irq),
    .busyFlag(busyFlag), .rdEmpty(rdEmpty), .cntLast(cntLast)
  );
endmodule

// File: rtl/rxr_checks.sv
module rxr_checks #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [ADDR_W-1:0] ringBase,
  input logic [15:0]       maxLen,
  input logic              rxValid,
  input logic [ADDR_W-1:0] dAddr,
  input logic              dWe,
  input logic [15:0]       dWdata,
  input logic              bWe,
  input logic              irq,
  input logic              busyFlag
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(7);

  p_len_before_stat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dWe && dAddr[2:0] == 3'd0) |-> ($past(dWe) && $past(dAddr[2:0]) == 3'd2));

  p_irq_after_stat_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(dWe && dAddr[2:0] == 3'd0 && dWdata[12]));

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  p_byte_from_input_r2: assert property (@(posedge clk) disable iff (!rstN)
    bWe |-> $past(rxValid));

  p_busy_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    busyFlag |=> busyFlag);

  p_wrap_to_base_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dWe && dAddr[2:0] == 3'd0 && dWdata[13] && $stable(ringBase))
      |=> (dAddr == (ringBase & ALIGN_MASK)));

  p_maxlen_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> (maxLen != 16'd0));
endmodule

bind rx_bd_ring rxr_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .ringBase(ringBase), .maxLen(maxLen),
  .rxValid(rxValid), .dAddr(dAddr), .dWe(dWe), .dWdata(dWdata), .bWe(bWe),
  .irq(irq), .busyFlag(busyFlag)
);

// File: tb/sim_rx_bd_ring.sv
module sim_rx_bd_ring;
  logic        clk = 1'b0;
  logic        rstN, enable, rxValid, rxEnd;
  logic [15:0] ringBase, maxLen, dAddr, dWdata, dRdata;
  logic [7:0]  rxByte, bData;
  logic        dWe, bWe, irq, busyFlag;
  logic [31:0] bAddr;

  always #5 clk = ~clk;

  rx_bd_ring #(.ADDR_W(16)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .ringBase(ringBase), .maxLen(maxLen),
    .rxValid(rxValid), .rxByte(rxByte), .rxEnd(rxEnd), .dAddr(dAddr), .dWe(dWe),
    .dWdata(dWdata), .dRdata(dRdata), .bWe(bWe), .bAddr(bAddr), .bData(bData),
    .irq(irq), .busyFlag(busyFlag)
  );

  logic [15:0] mem [0:63];
  always @(posedge clk) begin
    dRdata <= mem[dAddr[6:1]];
    if (dWe) mem[dAddr[6:1]] <= dWdata;
  end

  typedef struct {
    logic [31:0] addr;
    logic [15:0] data;
    bit          irqE;
    string       req;
  } expItem_t;

  expItem_t byteQ[$];
  expItem_t descQ[$];
  expItem_t it;
  int  nChk = 0;
  int  nFail = 0;
  bit  done = 1'b0;
  bit  irqPend = 1'b0;
  bit  irqExp;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expByte(input logic [31:0] a, input logic [7:0] d, input string req);
    expItem_t x;
    x.addr = a; x.data = {8'h00, d}; x.irqE = 1'b0; x.req = req;
    byteQ.push_back(x);
  endtask

  task automatic expDesc(input logic [31:0] a, input logic [15:0] d, input bit ie,
                         input string req);
    expItem_t x;
    x.addr = a; x.data = d; x.irqE = ie; x.req = req;
    descQ.push_back(x);
  endtask

  task automatic putByte(input logic [7:0] b, input logic e);
    rxValid = 1'b1; rxByte = b; rxEnd = e;
    @(posedge clk); #1;
  endtask

  task automatic stopRx;
    rxValid = 1'b0; rxEnd = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: compares design writes and the interrupt against the scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (irqPend) begin
        check(irq == irqExp, "R8", "irq after status write", 32'(irq), 32'(irqExp));
        irqPend = 1'b0;
      end else if (irq) begin
        check(1'b0, "R8", "unexpected irq", 32'd1, 32'd0);
      end
      if (bWe) begin
        if (byteQ.size() == 0) check(1'b0, "R2", "unexpected byte write", bAddr, 32'd0);
        else begin
          it = byteQ.pop_front();
          check(bAddr == it.addr, it.req, "byte address", bAddr, it.addr);
          check(bData == it.data[7:0], it.req, "byte data", 32'(bData), 32'(it.data[7:0]));
        end
      end
      if (dWe) begin
        if (descQ.size() == 0) check(1'b0, "R5", "unexpected descriptor write", 32'(dAddr), 32'd0);
        else begin
          it = descQ.pop_front();
          check(32'(dAddr) == it.addr, it.req, "descriptor write address", 32'(dAddr), it.addr);
          check(dWdata == it.data, it.req, "descriptor write data", 32'(dWdata), 32'(it.data));
          if (dAddr[2:0] == 3'd0) begin
            irqPend = 1'b1;
            irqExp  = it.irqE;
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nFail++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 20000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    // ring at byte 0x10: three descriptors, the last one wraps
    mem[8]  = 16'h9000; mem[9]  = 16'h0000; mem[10] = 16'h0000; mem[11] = 16'h1000;
    mem[12] = 16'h8000; mem[13] = 16'h0000; mem[14] = 16'h0000; mem[15] = 16'h2000;
    mem[16] = 16'hB000; mem[17] = 16'h0000; mem[18] = 16'h0000; mem[19] = 16'h3000;
    rstN = 1'b0; enable = 1'b0; ringBase = 16'h0013; maxLen = 16'd4;
    rxValid = 1'b0; rxByte = 8'h00; rxEnd = 1'b0;
    waitCyc(3);
    @(negedge clk);
    check(bWe == 1'b0, "R2", "reset bWe", 32'(bWe), 32'd0);
    check(dWe == 1'b0, "R5", "reset dWe", 32'(dWe), 32'd0);
    check(irq == 1'b0, "R8", "reset irq", 32'(irq), 32'd0);
    check(busyFlag == 1'b0, "R10", "reset busy", 32'(busyFlag), 32'd0);
    @(posedge clk); #1;
    rstN = 1'b1;

    // R1: bytes while disabled are ignored
    waitCyc(2);
    putByte(8'h55, 1'b1);
    stopRx;
    waitCyc(4);
    @(negedge clk);
    check(busyFlag == 1'b0, "R1", "busy after byte while disabled", 32'(busyFlag), 32'd0);
    @(posedge clk); #1;
    enable = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(dAddr == 16'h0010, "R1", "first status read at aligned base", 32'(dAddr), 32'h10);
    waitCyc(8);

    // R3: buffer fills to the maximum length
    for (int i = 0; i < 4; i++) expByte(32'h1000 + 32'(i), 8'hA0 + 8'(i), "R3");
    expDesc(32'h12, 16'd4, 1'b0, "R3");
    expDesc(32'h10, 16'h1000, 1'b1, "R5");
    for (int i = 0; i < 4; i++) putByte(8'hA0 + 8'(i), 1'b0);
    stopRx;
    waitCyc(12);

    // R4: end of message closes early, Last set, no interrupt
    expByte(32'h2000, 8'hB0, "R4");
    expByte(32'h2001, 8'hB1, "R4");
    expDesc(32'h1A, 16'd2, 1'b0, "R4");
    expDesc(32'h18, 16'h0800, 1'b0, "R4");
    putByte(8'hB0, 1'b0);
    putByte(8'hB1, 1'b1);
    stopRx;
    waitCyc(12);

    // R9: extra byte lands in write-back and is dropped; R7: wrap afterwards
    for (int i = 0; i < 4; i++) expByte(32'h3000 + 32'(i), 8'hC0 + 8'(i), "R9");
    expDesc(32'h22, 16'd4, 1'b0, "R9");
    expDesc(32'h20, 16'h3000, 1'b1, "R7");
    for (int i = 0; i < 5; i++) putByte(8'hC0 + 8'(i), 1'b0);
    stopRx;
    waitCyc(12);
    @(negedge clk);
    check(busyFlag == 1'b0, "R9", "overrun drop leaves busy low", 32'(busyFlag), 32'd0);
    @(posedge clk); #1;

    // R10: wrapped onto a used descriptor; byte while polling raises busy
    putByte(8'hD9, 1'b0);
    stopRx;
    @(negedge clk);
    check(busyFlag == 1'b1, "R10", "busy after drop while polling", 32'(busyFlag), 32'd1);
    // release descriptor 0 with continuous mode (R6)
    mem[8] = 16'h9200;
    for (int i = 0; i < 4; i++) expByte(32'h1000 + 32'(i), 8'hE0 + 8'(i), "R6");
    expDesc(32'h12, 16'd4, 1'b0, "R3");
    expDesc(32'h10, 16'h9202, 1'b1, "R6");
    waitCyc(10);
    putByte(8'hE0, 1'b0);
    maxLen = 16'd2;  // R3: only the next descriptor sees this
    for (int i = 1; i < 4; i++) putByte(8'hE0 + 8'(i), 1'b0);
    stopRx;
    waitCyc(12);
    @(negedge clk);
    check(busyFlag == 1'b1, "R10", "busy stays set", 32'(busyFlag), 32'd1);
    mem[12] = 16'h8000;
    @(posedge clk); #1;

    // R3: new maximum applies to this descriptor
    expByte(32'h2000, 8'hF0, "R3");
    expByte(32'h2001, 8'hF1, "R3");
    expDesc(32'h1A, 16'd2, 1'b0, "R3");
    expDesc(32'h18, 16'h0000, 1'b0, "R5");
    waitCyc(10);
    putByte(8'hF0, 1'b0);
    putByte(8'hF1, 1'b0);
    stopRx;
    waitCyc(12);

    @(negedge clk);
    check(byteQ.size() == 0, "R2", "pending byte writes", 32'(byteQ.size()), 32'd0);
    check(descQ.size() == 0, "R5", "pending descriptor writes", 32'(descQ.size()), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule